// File: doc/BRIEF.md
# MDIO Transaction Engine

This block lets a host run single PHY register accesses on a management data bus. Software first fills a data register and, for clause-45 accesses, an extended-address register. For writes it also fills a 64-bit target map. It then writes an access word with the start bit set. The engine builds the management frames, shifts them out on MDC/MDIO, captures read data and clears the start bit when the job is done. Software polls that bit to see when the job has finished.

A clause-22 access on a non-raw page is preceded by a page-select write to register 31. A clause-45 access is preceded by an address frame. A write runs once for every selected port, lowest port first. Ports at or above the CPU port index can never be addressed. A request that names no eligible port is refused at once and sets a fail flag. Software can abort a running job by writing the access word with the start bit clear.

CSR word addresses: 0 access word, 1 data, 2 extended address, 3 port map bits 31:0, 4 port map bits 63:32. Registers are read back combinationally.

Top module: `mdio_cmd_engine`

## Requirements
- R1: Access word fields are: bit 0 start/busy, bit 1 fail (read-only), bit 2 clause-45 select, bit 3 write select, bits 9:5 register, bits 22:10 page, bits 27:23 raw tag. Writing it with bit 0 set while idle starts a job. Bit 0 reads 1 while the job runs and 0 once it has ended. The `busy` port follows it.
- R2: A clause-22 frame is 32 ones of preamble, then MSB first: start 01, opcode (10 read, 01 write), 5-bit PHY address (port bits 4:0), 5-bit register, turnaround 10 and 16 data bits.
- R3: A read takes its port from data bits 31:16 and returns the result in data bits 15:0. Bits 31:16 are kept.
- R4: When the page is not raw, each clause-22 access is preceded by a clause-22 write of the page value to register 31. A raw page is 0x1FFF together with a raw tag of 0x1F, and it sends no page frame.
- R5: A write sends data bits 31:16 to every port whose map bit is set, in ascending port order.
- R6: A clause-45 access sends an address frame (start 00, opcode 00, device from extended bits 20:16, data from extended bits 15:0). It then sends the access frame (start 00, opcode 01 write or 11 read). The page field is ignored.
- R7: A read of a port at or above CPU_PORT is refused and no frame is sent. Map bits at or above CPU_PORT are dropped. Port CPU_PORT-1 is still served.
- R8: Fail is set by a write with no eligible map bit, by a refused read, by page 0x1FFF with a raw tag other than 0x1F, and by an aborted write. Any of these refusals sends no frame. Fail clears when the next job is accepted.
- R9: Writing the access word with bit 0 clear while busy stops the job on the next edge. MDIO is released, MDC goes low and bit 0 clears.
- R10: While busy, CSR writes other than an abort are ignored.
- R11: MDC stays high for HALF_DIV cycles and low for HALF_DIV cycles. MDIO changes only while MDC is low. The engine releases MDIO for turnaround and data of read frames and samples it on MDC rising edges.
- R12: After reset every register reads 0, MDC is low and MDIO is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr | input | 1 | CSR write strobe |
| csr_addr | input | 3 | CSR word address |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data for csr_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |
| busy | output | 1 | Job in progress |

## Verification
The clock properties assume HALF_DIV of at least two. They also assume an abort is only a CSR write to the access word with bit 0 clear. The bench keeps to both: it runs with the default divider and issues aborts only through that write. The bench stands in for a PHY. It turns the bus only during read turnaround and data, drives each bit after an MDC falling edge, and keeps MDIO high elsewhere. It never changes CSR inputs on an active edge.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;
   localparam int CSR_W      = 32;
   localparam int BMP_W      = 64;
   localparam int PORT_W     = 6;
   localparam int PHY_W      = 5;
   localparam int REG_W      = 5;
   localparam int PAGE_W     = 13;
   localparam int TAG_W      = 5;
   localparam int DAT_W      = 16;
   localparam int FRAME_W    = 32;
   localparam int PREAMBLE_W = 32;
   localparam logic [PAGE_W-1:0] RAW_PAGE = '1;
   localparam logic [TAG_W-1:0]  RAW_TAG  = '1;
   localparam logic [REG_W-1:0]  PSEL_REG = 5'd31;

   localparam int CB_EXEC  = 0;
   localparam int CB_FAIL  = 1;
   localparam int CB_MMD   = 2;
   localparam int CB_WRITE = 3;
   localparam logic [CSR_W-1:0] CTRL_KEEP = 32'h0FFF_FFEC;
   localparam logic [CSR_W-1:0] XADR_KEEP = 32'h001F_FFFF;

   typedef enum logic [2:0] {
      CSR_CTRL = 3'd0, CSR_DATA = 3'd1, CSR_XADR = 3'd2,
      CSR_MAPL = 3'd3, CSR_MAPH = 3'd4
   } csr_sel_e;

   typedef enum logic [1:0] {SQ_IDLE, SQ_LOAD, SQ_ISSUE, SQ_WAIT} seq_state_e;

   function automatic logic [PORT_W-1:0] lowest_set(input logic [BMP_W-1:0] v);
      lowest_set = '0;
      for (int i = BMP_W - 1; i >= 0; i--)
         if (v[i]) lowest_set = PORT_W'(i);
   endfunction
endpackage

// File: rtl/mdio_csr_file.sv
module mdio_csr_file
   import mdio_cmd_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csr_wr,
   input  logic [2:0]        csr_addr,
   input  logic [CSR_W-1:0]  csr_wdata,
   output logic [CSR_W-1:0]  csr_rdata,
   input  logic              busy,
   input  logic              fail,
   input  logic              cap_we,
   input  logic [DAT_W-1:0]  cap_data,
   output logic              go,
   output logic              abort,
   output logic              f_wr,
   output logic              f_mmd,
   output logic [REG_W-1:0]  f_reg,
   output logic [PAGE_W-1:0] f_page,
   output logic [TAG_W-1:0]  f_tag,
   output logic [DAT_W-1:0]  f_port,
   output logic [DAT_W-1:0]  f_wdat,
   output logic [PHY_W-1:0]  f_dev,
   output logic [DAT_W-1:0]  f_xreg,
   output logic [BMP_W-1:0]  f_map
);
   logic [CSR_W-1:0] ctrl_q, data_q, xadr_q;
   logic [BMP_W-1:0] map_q;
   logic             wr_ctrl;

   assign wr_ctrl = csr_wr && (csr_addr == CSR_CTRL);
   assign go      = wr_ctrl && !busy && csr_wdata[CB_EXEC];
   assign abort   = wr_ctrl && busy && !csr_wdata[CB_EXEC];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         data_q <= '0;
         xadr_q <= '0;
         map_q  <= '0;
      end else begin
         if (csr_wr && !busy) begin
            case (csr_addr)
               CSR_CTRL: ctrl_q <= csr_wdata & CTRL_KEEP;
               CSR_DATA: data_q <= csr_wdata;
               CSR_XADR: xadr_q <= csr_wdata & XADR_KEEP;
               CSR_MAPL: map_q[CSR_W-1:0] <= csr_wdata;
               CSR_MAPH: map_q[BMP_W-1:CSR_W] <= csr_wdata;
               default: ;
            endcase
         end
         if (cap_we) data_q[DAT_W-1:0] <= cap_data;
      end
   end

   always_comb begin
      case (csr_addr)
         CSR_CTRL: csr_rdata = ctrl_q | {{(CSR_W-2){1'b0}}, fail, busy};
         CSR_DATA: csr_rdata = data_q;
         CSR_XADR: csr_rdata = xadr_q;
         CSR_MAPL: csr_rdata = map_q[CSR_W-1:0];
         CSR_MAPH: csr_rdata = map_q[BMP_W-1:CSR_W];
         default:  csr_rdata = '0;
      endcase
   end

   assign f_wr   = ctrl_q[CB_WRITE];
   assign f_mmd  = ctrl_q[CB_MMD];
   assign f_reg  = ctrl_q[9:5];
   assign f_page = ctrl_q[22:10];
   assign f_tag  = ctrl_q[27:23];
   assign f_port = data_q[CSR_W-1:DAT_W];
   assign f_wdat = data_q[CSR_W-1:DAT_W];
   assign f_dev  = xadr_q[20:16];
   assign f_xreg = xadr_q[DAT_W-1:0];
   assign f_map  = map_q;
endmodule

// File: rtl/mdio_access_seq.sv
module mdio_access_seq
   import mdio_cmd_pkg::*;
#(
   parameter int CPU_PORT = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               go,
   input  logic               abort,
   input  logic               f_wr,
   input  logic               f_mmd,
   input  logic [REG_W-1:0]   f_reg,
   input  logic [PAGE_W-1:0]  f_page,
   input  logic [TAG_W-1:0]   f_tag,
   input  logic [DAT_W-1:0]   f_port,
   input  logic [DAT_W-1:0]   f_wdat,
   input  logic [PHY_W-1:0]   f_dev,
   input  logic [DAT_W-1:0]   f_xreg,
   input  logic [BMP_W-1:0]   f_map,
   input  logic               frm_done,
   input  logic [DAT_W-1:0]   frm_rdata,
   output logic               busy,
   output logic               fail,
   output logic               frm_start,
   output logic               frm_rd,
   output logic [FRAME_W-1:0] frm_word,
   output logic               cap_we,
   output logic [DAT_W-1:0]   cap_data
);
   localparam logic [BMP_W-1:0] ELIGIBLE = (BMP_W'(1) << CPU_PORT) - BMP_W'(1);

   seq_state_e        state;
   logic [BMP_W-1:0]  pend, pend_new, pend_left;
   logic              step;
   logic              is_raw, bad_tag, skip_pre;
   logic [PORT_W-1:0] cur;
   logic [PHY_W-1:0]  phy;

   assign is_raw   = (f_page == RAW_PAGE);
   assign bad_tag  = is_raw && (f_tag != RAW_TAG);
   assign skip_pre = !f_mmd && is_raw;
   assign cur      = lowest_set(pend);
   assign phy      = cur[PHY_W-1:0];
   assign pend_new = f_wr ? (f_map & ELIGIBLE)
                   : ((f_port < DAT_W'(CPU_PORT)) ? (BMP_W'(1) << f_port[PORT_W-1:0]) : '0);
   assign pend_left = pend & ~(BMP_W'(1) << cur);

   always_comb begin
      if (!step && f_mmd)
         frm_word = {2'b00, 2'b00, phy, f_dev, 2'b10, f_xreg};
      else if (!step)
         frm_word = {2'b01, 2'b01, phy, PSEL_REG, 2'b10, DAT_W'(f_page)};
      else if (f_mmd)
         frm_word = {2'b00, f_wr ? 2'b01 : 2'b11, phy, f_dev, 2'b10, f_wdat};
      else
         frm_word = {2'b01, f_wr ? 2'b01 : 2'b10, phy, f_reg, 2'b10, f_wdat};
   end

   assign frm_start = (state == SQ_ISSUE);
   assign frm_rd    = step && !f_wr;
   assign cap_we    = (state == SQ_WAIT) && frm_done && step && !f_wr;
   assign cap_data  = frm_rdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= SQ_IDLE;
         pend  <= '0;
         step  <= 1'b0;
         busy  <= 1'b0;
         fail  <= 1'b0;
      end else if (abort) begin
         state <= SQ_IDLE;
         busy  <= 1'b0;
         fail  <= f_wr;
      end else begin
         unique case (state)
            SQ_IDLE: if (go) begin
               busy  <= 1'b1;
               fail  <= 1'b0;
               state <= SQ_LOAD;
            end
            SQ_LOAD: if (bad_tag || pend_new == '0) begin
               busy  <= 1'b0;
               fail  <= 1'b1;
               state <= SQ_IDLE;
            end else begin
               pend  <= pend_new;
               step  <= skip_pre;
               state <= SQ_ISSUE;
            end
            SQ_ISSUE: state <= SQ_WAIT;
            SQ_WAIT: if (frm_done) begin
               if (!step) begin
                  step  <= 1'b1;
                  state <= SQ_ISSUE;
               end else begin
                  pend <= pend_left;
                  if (pend_left != '0) begin
                     step  <= skip_pre;
                     state <= SQ_ISSUE;
                  end else begin
                     busy  <= 1'b0;
                     state <= SQ_IDLE;
                  end
               end
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter
   import mdio_cmd_pkg::*;
#(
   parameter int HALF_DIV = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               abort,
   input  logic               rd,
   input  logic [FRAME_W-1:0] frame,
   input  logic               mdio_i,
   output logic               mdc,
   output logic               mdio_o,
   output logic               mdio_oe,
   output logic               done,
   output logic [DAT_W-1:0]   rd_data
);
   localparam int BITS     = PREAMBLE_W + FRAME_W;
   localparam int IDX_W    = $clog2(BITS);
   localparam int CNT_W    = $clog2(HALF_DIV);
   localparam int TA_IDX   = PREAMBLE_W + 14;
   localparam int DATA_IDX = BITS - DAT_W;

   logic             active, rd_q;
   logic [BITS-1:0]  sr;
   logic [IDX_W-1:0] idx;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active  <= 1'b0;
         rd_q    <= 1'b0;
         sr      <= '0;
         idx     <= '0;
         cnt     <= '0;
         mdc     <= 1'b0;
         done    <= 1'b0;
         rd_data <= '0;
      end else begin
         done <= 1'b0;
         if (abort) begin
            active <= 1'b0;
            mdc    <= 1'b0;
         end else if (start) begin
            active <= 1'b1;
            rd_q   <= rd;
            sr     <= {{PREAMBLE_W{1'b1}}, frame};
            idx    <= '0;
            cnt    <= '0;
            mdc    <= 1'b0;
         end else if (active) begin
            if (cnt == CNT_W'(HALF_DIV - 1)) begin
               cnt <= '0;
               if (!mdc) begin
                  mdc <= 1'b1;
                  if (rd_q && idx >= IDX_W'(DATA_IDX))
                     rd_data <= {rd_data[DAT_W-2:0], mdio_i};
               end else begin
                  mdc <= 1'b0;
                  if (idx == IDX_W'(BITS - 1)) begin
                     active <= 1'b0;
                     done   <= 1'b1;
                  end else begin
                     idx <= idx + 1'b1;
                     sr  <= {sr[BITS-2:0], 1'b0};
                  end
               end
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   assign mdio_o  = sr[BITS-1];
   assign mdio_oe = active && !(rd_q && idx >= IDX_W'(TA_IDX));
endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
   import mdio_cmd_pkg::*;
#(
   parameter int CPU_PORT = 32,
   parameter int HALF_DIV = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        csr_wr,
   input  logic [2:0]  csr_addr,
   input  logic [31:0] csr_wdata,
   output logic [31:0] csr_rdata,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe,
   input  logic        mdio_i,
   output logic        busy
);
   if (CPU_PORT < 1 || CPU_PORT > (1 << PHY_W)) begin : g_bad_cpu_port
      $error("CPU_PORT must lie in 1..32 so every port has its own PHY address");
   end
   if (HALF_DIV < 2) begin : g_bad_div
      $error("HALF_DIV must be at least 2");
   end

   logic              go, abort, seq_busy, seq_fail, cap_we;
   logic [DAT_W-1:0]  cap_data, frm_rdata;
   logic              f_wr, f_mmd;
   logic [REG_W-1:0]  f_reg;
   logic [PAGE_W-1:0] f_page;
   logic [TAG_W-1:0]  f_tag;
   logic [DAT_W-1:0]  f_port, f_wdat, f_xreg;
   logic [PHY_W-1:0]  f_dev;
   logic [BMP_W-1:0]  f_map;
   logic              frm_start, frm_rd, frm_done;
   logic [FRAME_W-1:0] frm_word;

   mdio_csr_file u_csr (
      .clk, .rst_n, .csr_wr, .csr_addr, .csr_wdata, .csr_rdata,
      .busy(seq_busy), .fail(seq_fail), .cap_we, .cap_data,
      .go, .abort, .f_wr, .f_mmd, .f_reg, .f_page, .f_tag,
      .f_port, .f_wdat, .f_dev, .f_xreg, .f_map
   );

   mdio_access_seq #(.CPU_PORT(CPU_PORT)) u_seq (
      .clk, .rst_n, .go, .abort, .f_wr, .f_mmd, .f_reg, .f_page, .f_tag,
      .f_port, .f_wdat, .f_dev, .f_xreg, .f_map, .frm_done, .frm_rdata,
      .busy(seq_busy), .fail(seq_fail), .frm_start, .frm_rd, .frm_word,
      .cap_we, .cap_data
   );

   mdio_frame_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
      .clk, .rst_n, .start(frm_start), .abort, .rd(frm_rd), .frame(frm_word),
      .mdio_i, .mdc, .mdio_o, .mdio_oe, .done(frm_done), .rd_data(frm_rdata)
   );

   assign busy = seq_busy;
endmodule

// File: rtl/mdio_cmd_engine_chk.sv
module mdio_cmd_engine_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       csr_wr,
   input logic [2:0] csr_addr,
   input logic       exec_bit,
   input logic       busy,
   input logic       fail,
   input logic       mdc,
   input logic       mdio_o,
   input logic       mdio_oe
);
   logic abort_now;
   assign abort_now = csr_wr && (csr_addr == 3'd0) && !exec_bit && busy;

   a_r11_line_quiet_while_mdc_high: assert property (@(posedge clk) disable iff (!rst_n)
      (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

   a_r11_mdc_high_min: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(mdc) && !abort_now) |=> mdc);

   a_r9_abort_releases: assert property (@(posedge clk) disable iff (!rst_n)
      abort_now |=> (!busy && !mdio_oe && !mdc));

   a_r1_idle_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mdio_oe && !mdc));

   a_r8_fail_clears_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !fail);
endmodule

bind mdio_cmd_engine mdio_cmd_engine_chk u_chk (
   .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_addr(csr_addr),
   .exec_bit(csr_wdata[0]), .busy(busy), .fail(seq_fail), .mdc(mdc),
   .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/tb_mdio_cmd_engine.sv
`timescale 1ns/1ps
module tb_mdio_cmd_engine;
   localparam int HALF = 2;
   localparam logic [31:0] RAWW = (32'h1F << 23) | (32'h1FFF << 10);

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csr_wr = 1'b0;
   logic [2:0]  csr_addr = 3'd0;
   logic [31:0] csr_wdata = 32'd0;
   logic [31:0] csr_rdata;
   logic        mdc, mdio_o, mdio_oe, busy;
   logic        mdio_i = 1'b1;

   int nchk = 0, nerr = 0;
   logic [31:0] frames [0:31];
   int nfr = 0, bcnt = 0, pre_err = 0, oe_err = 0;
   int hi_run = 0, hi_min = 1000, hi_max = 0;
   logic [63:0] fb = '0;
   logic is_rd = 1'b0, mdc_d = 1'b0;
   logic [15:0] resp = 16'h0;

   mdio_cmd_engine #(.CPU_PORT(32), .HALF_DIV(HALF)) dut (
      .clk, .rst_n, .csr_wr, .csr_addr, .csr_wdata, .csr_rdata,
      .mdc, .mdio_o, .mdio_oe, .mdio_i, .busy
   );

   always #2 clk = ~clk;

   // PHY stand-in: records frames on MDC rise, drives read data after MDC fall
   always @(negedge clk) begin
      logic bv;
      if (!busy) begin bcnt = 0; is_rd = 1'b0; end
      if (mdc && !mdc_d) begin
         bv = mdio_oe ? mdio_o : mdio_i;
         fb = {fb[62:0], bv};
         if (bcnt < 32 && !(mdio_oe && mdio_o)) pre_err++;
         if (is_rd && bcnt >= 46) begin if (mdio_oe) oe_err++; end
         else if (!mdio_oe) oe_err++;
         if (bcnt == 34) is_rd = bv;
         bcnt++;
         if (bcnt == 64) begin
            if (nfr < 32) frames[nfr] = fb[31:0];
            nfr++;
            bcnt = 0;
            is_rd = 1'b0;
         end
      end
      if (!mdc && mdc_d) begin
         if (is_rd && bcnt >= 48) mdio_i = resp[63-bcnt];
         else if (is_rd && bcnt == 47) mdio_i = 1'b0;
         else mdio_i = 1'b1;
      end
      if (mdc) hi_run++;
      else if (mdc_d) begin
         if (hi_run < hi_min) hi_min = hi_run;
         if (hi_run > hi_max) hi_max = hi_run;
         hi_run = 0;
      end
      mdc_d = mdc;
   end

   function automatic logic [31:0] fr(input logic [1:0] st, input logic [1:0] op,
                                      input logic [4:0] phy, input logic [4:0] rg,
                                      input logic [15:0] d);
      fr = {st, op, phy, rg, 2'b10, d};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic csr_write(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
      @(negedge clk);
      csr_wr = 1'b0;
   endtask

   task automatic csr_read(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      csr_addr = a;
      #1 d = csr_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] v;
      for (int i = 0; i < 20000; i++) begin
         csr_read(3'd0, v);
         if (!v[0]) break;
      end
   endtask

   task automatic t_reset();
      logic [31:0] v;
      for (int a = 0; a < 5; a++) begin
         csr_read(3'(a), v);
         chk("R12 register after reset", v, 32'h0);
      end
      chk("R12 mdc/oe/busy after reset", {29'd0, mdc, mdio_oe, busy}, 32'h0);
   endtask

   task automatic t_raw_read();
      logic [31:0] v;
      int n0 = nfr;
      resp = 16'hBEEF;
      csr_write(3'd1, 32'h0005_0000);
      csr_write(3'd0, RAWW | (32'd3 << 5) | 32'd1);
      csr_read(3'd0, v);
      chk("R1 start bit reads 1 while running", {31'd0, v[0]}, 32'd1);
      chk("R1 busy port while running", {31'd0, busy}, 32'd1);
      wait_idle();
      csr_read(3'd0, v);
      chk("R1 start bit cleared, fields kept", v, RAWW | (32'd3 << 5));
      chk("R4 raw page sends one frame", nfr - n0, 1);
      chk("R2 clause-22 read frame", frames[n0], fr(2'b01, 2'b10, 5'd5, 5'd3, 16'hBEEF));
      csr_read(3'd1, v);
      chk("R3 read result and port kept", v, 32'h0005_BEEF);
   endtask

   task automatic t_paged_read();
      logic [31:0] v;
      int n0 = nfr;
      resp = 16'h1357;
      csr_write(3'd1, 32'h0006_0000);
      csr_write(3'd0, (32'h0A3 << 10) | (32'd17 << 5) | 32'd1);
      wait_idle();
      chk("R4 paged read sends two frames", nfr - n0, 2);
      chk("R4 page select write first", frames[n0], fr(2'b01, 2'b01, 5'd6, 5'd31, 16'h00A3));
      chk("R4 read after page select", frames[n0+1], fr(2'b01, 2'b10, 5'd6, 5'd17, 16'h1357));
      csr_read(3'd1, v);
      chk("R3 paged read result", v, 32'h0006_1357);
   endtask

   task automatic t_bitmap_write();
      logic [31:0] v;
      int n0 = nfr;
      csr_write(3'd3, 32'h0000_0084);
      csr_write(3'd4, 32'h0000_0100);
      csr_write(3'd1, 32'h5A5A_0000);
      csr_write(3'd0, RAWW | (32'd9 << 5) | 32'h9);
      wait_idle();
      chk("R7 high map bit dropped, two frames", nfr - n0, 2);
      chk("R5 write to port 2 first", frames[n0], fr(2'b01, 2'b01, 5'd2, 5'd9, 16'h5A5A));
      chk("R5 write to port 7 second", frames[n0+1], fr(2'b01, 2'b01, 5'd7, 5'd9, 16'h5A5A));
      csr_read(3'd0, v);
      chk("R8 no fail on good write", {31'd0, v[1]}, 32'd0);
   endtask

   task automatic t_c45_write();
      int n0 = nfr;
      csr_write(3'd3, 32'h0000_0010);
      csr_write(3'd4, 32'h0);
      csr_write(3'd2, 32'h0003_1234);
      csr_write(3'd1, 32'h00C3_0000);
      csr_write(3'd0, (32'h0A3 << 10) | 32'hD);
      wait_idle();
      chk("R6 clause-45 write sends two frames", nfr - n0, 2);
      chk("R6 address frame", frames[n0], fr(2'b00, 2'b00, 5'd4, 5'd3, 16'h1234));
      chk("R6 write frame", frames[n0+1], fr(2'b00, 2'b01, 5'd4, 5'd3, 16'h00C3));
   endtask

   task automatic t_c45_read();
      logic [31:0] v;
      int n0 = nfr;
      resp = 16'hA55A;
      csr_write(3'd2, 32'h0001_0007);
      csr_write(3'd1, 32'h0009_0000);
      csr_write(3'd0, RAWW | 32'h5);
      wait_idle();
      chk("R6 clause-45 read sends two frames", nfr - n0, 2);
      chk("R6 read address frame", frames[n0], fr(2'b00, 2'b00, 5'd9, 5'd1, 16'h0007));
      chk("R6 read frame", frames[n0+1], fr(2'b00, 2'b11, 5'd9, 5'd1, 16'hA55A));
      csr_read(3'd1, v);
      chk("R3 clause-45 read result", v, 32'h0009_A55A);
   endtask

   task automatic t_reject_port();
      logic [31:0] v;
      int n0 = nfr;
      csr_write(3'd1, 32'h0020_0000);
      csr_write(3'd0, RAWW | 32'd1);
      wait_idle();
      csr_read(3'd0, v);
      chk("R7 port 32 refused with fail", v[1:0], 32'b10);
      chk("R7 no frame for refused port", nfr - n0, 0);
      resp = 16'h0F0F;
      csr_write(3'd1, 32'h001F_0000);
      csr_write(3'd0, RAWW | (32'd2 << 5) | 32'd1);
      wait_idle();
      chk("R7 port 31 served", nfr - n0, 1);
      chk("R7 port 31 frame", frames[n0], fr(2'b01, 2'b10, 5'd31, 5'd2, 16'h0F0F));
      csr_read(3'd0, v);
      chk("R8 fail cleared by accepted job", {31'd0, v[1]}, 32'd0);
   endtask

   task automatic t_fail_cases();
      logic [31:0] v;
      int n0 = nfr;
      csr_write(3'd3, 32'h0);
      csr_write(3'd4, 32'h0000_0001);
      csr_write(3'd0, RAWW | 32'h9);
      wait_idle();
      csr_read(3'd0, v);
      chk("R8 write with no eligible port fails", {31'd0, v[1]}, 32'd1);
      csr_write(3'd1, 32'h0003_0000);
      csr_write(3'd0, (32'h1FFF << 10) | 32'd1);
      wait_idle();
      csr_read(3'd0, v);
      chk("R8 raw page with wrong tag fails", {31'd0, v[1]}, 32'd1);
      chk("R8 refused jobs send no frame", nfr - n0, 0);
   endtask

   task automatic t_abort();
      logic [31:0] v;
      int n0 = nfr;
      csr_write(3'd3, 32'h0000_000A);
      csr_write(3'd4, 32'h0);
      csr_write(3'd1, 32'h7777_0000);
      csr_write(3'd0, RAWW | 32'h9);
      repeat (60) @(negedge clk);
      csr_write(3'd0, 32'h0);
      chk("R9 bus released after abort", {30'd0, mdio_oe, mdc}, 32'd0);
      csr_read(3'd0, v);
      chk("R9 start bit cleared by abort", {31'd0, v[0]}, 32'd0);
      chk("R8 aborted write sets fail", {31'd0, v[1]}, 32'd1);
      repeat (300) @(negedge clk);
      chk("R9 no frame completes after abort", nfr - n0, 0);
   endtask

   task automatic t_busy_lock();
      logic [31:0] v;
      int n0 = nfr;
      resp = 16'h2468;
      csr_write(3'd1, 32'h0005_0000);
      csr_write(3'd0, RAWW | (32'd3 << 5) | 32'd1);
      csr_write(3'd1, 32'hFFFF_FFFF);
      csr_write(3'd3, 32'hFFFF_FFFF);
      csr_write(3'd0, RAWW | (32'd12 << 5) | 32'd1);
      wait_idle();
      chk("R10 second start ignored", nfr - n0, 1);
      chk("R10 running job unchanged", frames[n0], fr(2'b01, 2'b10, 5'd5, 5'd3, 16'h2468));
      csr_read(3'd1, v);
      chk("R10 data write ignored while busy", v, 32'h0005_2468);
      csr_read(3'd3, v);
      chk("R10 map write ignored while busy", v, 32'h0000_000A);
      csr_read(3'd0, v);
      chk("R10 access word write ignored", v, RAWW | (32'd3 << 5));
   endtask

   task automatic t_mdc_timing();
      chk("R11 shortest MDC high phase", hi_min, HALF);
      chk("R11 longest MDC high phase", hi_max, HALF);
      chk("R2 preamble all driven ones", pre_err, 0);
      chk("R11 drive/release per bit", oe_err, 0);
   endtask

   initial begin
      #(4 * 150000);
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nerr + 1, nchk + 1);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_raw_read();
      t_paged_read();
      t_bitmap_write();
      t_c45_write();
      t_c45_read();
      t_reject_port();
      t_fail_cases();
      t_abort();
      t_busy_lock();
      t_mdc_timing();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule